// File: doc/BRIEF.md
# PHY Quick-Status Interrupt Register

This block is the quick-status word of one Ethernet PHY channel. Station management reads it as a single 16-bit value. Transient events from the PHY datapath arrive as one-cycle pulses: receive error, false carrier, remote fault, descrambler unlock and jabber. Each pulse sets a sticky flag, and the flag holds until the word is read. The link-status bit latches low, so a link drop that lasts only one cycle still shows up at the next read. Partner pause, speed and duplex pass through as live levels. Two fields record the lowest and the highest autonegotiation state code seen since the last read.

Two bits can be written: a mode bit and a mask bit. The mode bit selects what the interrupt output reports. With the mode bit at 0, the interrupt reports any sticky error or a lost link. With the mode bit at 1, it reports link changes only, and bit 14 then shows a link-change flag instead of the false-carrier flag. The mask bit silences the interrupt in both modes. The interrupt output comes from a flop and always agrees with the word being returned in the same cycle.

Top module: `qsr_status_reg`

## Requirements
- R1: While reset is asserted, the interrupt output is 0, the mode and mask bits are 0, and every sticky, link and autonegotiation field reads 0.
- R2: A receive-error pulse sets bit 15 only while the speed input is 1 (100 Mb/s). At 10 Mb/s the pulse is ignored.
- R3: With the mode bit 7 at 0, a false-carrier pulse sets bit 14 only at 100 Mb/s. A remote-fault pulse sets bit 13 at either speed.
- R4: Bit 12 is set by an unlock pulse at 100 Mb/s and by a jabber pulse at 10 Mb/s. Each pulse is ignored at the other speed.
- R5: A sticky bit holds until a read. The read returns the value before clearing, and the bit clears on the next edge. An event that arrives in the read cycle is still set after the read.
- R6: Bit 11 falls in the cycle after the live link goes low. It stays 0, even after the link returns, until a read reloads it from the live link level.
- R7: Bits 10, 9 and 8 follow the partner-pause, speed and duplex inputs directly.
- R8: A write strobe loads wr_cfg[1] into mode bit 7 and wr_cfg[0] into mask bit 6 on the next edge.
- R9: With mode 0 and mask 0, irq is 1 exactly when any of bits 15:12 is 1 or bit 11 is 0. irq falls in the same cycle in which a read clears those causes.
- R10: With mode 1, bit 14 is a sticky flag that is set in any cycle in which the live link differs from its value one cycle earlier, and cleared by a read. irq equals that flag and ignores bits 15, 13, 12 and 11.
- R11: With the mask bit at 1, irq stays 0 in both modes, whatever the state of the flags.
- R12: Bits 5:3 hold the minimum and bits 2:0 the maximum autonegotiation code seen since the last read. On a read, both fields reload from the code present in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ev_rx_err | input | 1 | Receive-error pulse |
| ev_false_carrier | input | 1 | False-carrier pulse |
| ev_rem_fault | input | 1 | Remote-fault pulse |
| ev_unlock | input | 1 | Descrambler loss-of-lock pulse |
| ev_jabber | input | 1 | Jabber pulse |
| link_up | input | 1 | Live link level |
| partner_pause | input | 1 | Live partner pause request |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex |
| an_state | input | AN_W | Current autonegotiation state code |
| rd_stb | input | 1 | Register read strobe |
| wr_en | input | 1 | Configuration write strobe |
| wr_cfg | input | 2 | {mode, mask} write data |
| rd_data | output | 10+2*AN_W | Status word |
| irq | output | 1 | Registered interrupt |

## Verification
The bench builds the block with the default AN_W of 3, which makes the 16-bit layout exact. At that width the bench runs every ordered pair of state codes through the min/max trackers, all 64 of them. It also covers all eight combinations of the live levels. It runs every event input at both speeds, with irq checked in both modes, with and without the mask, and across link drops before and after a read.

// File: rtl/qsr_pkg.sv
package qsr_pkg;

  localparam int STK_RXERR = 0;
  localparam int STK_FCAR  = 1;
  localparam int STK_RFLT  = 2;
  localparam int STK_LOCK  = 3;
  localparam int STK_LCHG  = 4;
  localparam int STK_N     = 5;

  typedef struct packed {
    logic conf;
    logic mask;
  } qsr_cfg_t;

endpackage

// File: rtl/qsr_sticky_bank.sv
module qsr_sticky_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q,
  output logic [N-1:0] q_nxt
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign q_nxt[i] = set[i] | (q[i] & ~clr);

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q[i] && !clr |=> q[i]);
    // R5
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set[i] |=> !q[i]);
    // R5
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/qsr_link_track.sv
module qsr_link_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic link_up,
  output logic lstat_q,
  output logic lstat_nxt,
  output logic chg
);

  logic prev_q;

  assign lstat_nxt = clr ? link_up : (lstat_q & link_up);
  assign chg       = link_up ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      lstat_q <= 1'b0;
    end else begin
      prev_q  <= link_up;
      lstat_q <= lstat_nxt;
    end
  end

  // R6
  latch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> !lstat_q);
  // R6
  stay_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lstat_q && !clr |=> !lstat_q);

endmodule

// File: rtl/qsr_an_track.sv
module qsr_an_track #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] state,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q
);

  logic [W-1:0] lo_d, hi_d;

  always_comb begin
    if (clr) begin
      lo_d = state;
      hi_d = state;
    end else begin
      lo_d = (state < lo_q) ? state : lo_q;
      hi_d = (state > hi_q) ? state : hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // R12
  an_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q <= hi_q);
  // R12
  an_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lo_q == $past(state)) && (hi_q == $past(state)));
  // R12
  an_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (lo_q <= $past(state)) && (hi_q >= $past(state)));

endmodule

// File: rtl/qsr_status_reg.sv
module qsr_status_reg
  import qsr_pkg::*;
#(
  parameter int AN_W = 3,
  localparam int REG_W = 10 + 2 * AN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_rx_err,
  input  logic             ev_false_carrier,
  input  logic             ev_rem_fault,
  input  logic             ev_unlock,
  input  logic             ev_jabber,
  input  logic             link_up,
  input  logic             partner_pause,
  input  logic             speed_100,
  input  logic             full_duplex,
  input  logic [AN_W-1:0]  an_state,
  input  logic             rd_stb,
  input  logic             wr_en,
  input  logic [1:0]       wr_cfg,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);

  logic [STK_N-1:0] stk_set, stk_q, stk_d;
  logic             lstat_q, lstat_d, link_chg;
  logic [AN_W-1:0]  an_lo, an_hi;
  qsr_cfg_t         cfg_q, cfg_d;
  logic             irq_q, irq_d;

  always_comb begin
    stk_set            = '0;
    stk_set[STK_RXERR] = ev_rx_err & speed_100;
    stk_set[STK_FCAR]  = ev_false_carrier & speed_100;
    stk_set[STK_RFLT]  = ev_rem_fault;
    stk_set[STK_LOCK]  = speed_100 ? ev_unlock : ev_jabber;
    stk_set[STK_LCHG]  = link_chg;
  end

  qsr_sticky_bank #(.N(STK_N)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rd_stb),
    .set   (stk_set),
    .q     (stk_q),
    .q_nxt (stk_d)
  );

  qsr_link_track u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rd_stb),
    .link_up   (link_up),
    .lstat_q   (lstat_q),
    .lstat_nxt (lstat_d),
    .chg       (link_chg)
  );

  qsr_an_track #(.W(AN_W)) u_an (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rd_stb),
    .state (an_state),
    .lo_q  (an_lo),
    .hi_q  (an_hi)
  );

  // Configuration next state: loaded only on a write strobe.
  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = qsr_cfg_t'(wr_cfg);
  end

  // Interrupt computed from next-state values so the flop agrees with rd_data.
  always_comb begin
    if (cfg_d.mask)
      irq_d = 1'b0;
    else if (cfg_d.conf)
      irq_d = stk_d[STK_LCHG];
    else
      irq_d = stk_d[STK_RXERR] | stk_d[STK_FCAR] | stk_d[STK_RFLT] |
              stk_d[STK_LOCK] | ~lstat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  assign rd_data = {stk_q[STK_RXERR],
                    cfg_q.conf ? stk_q[STK_LCHG] : stk_q[STK_FCAR],
                    stk_q[STK_RFLT],
                    stk_q[STK_LOCK],
                    lstat_q,
                    partner_pause,
                    speed_100,
                    full_duplex,
                    cfg_q.conf,
                    cfg_q.mask,
                    an_lo,
                    an_hi};

  // R11
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.mask |-> !irq_q);
  // R10
  mode1_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.conf && !stk_q[STK_LCHG] |-> !irq_q);
  // R8
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> {cfg_q.conf, cfg_q.mask} == $past(wr_cfg));
  // R9
  mode0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.conf && lstat_q && (stk_q[STK_LCHG:0] & 5'b01111) == '0 |-> !irq_q);

endmodule

// File: tb/qsr_status_reg_tb.sv
module qsr_status_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_rx_err, ev_false_carrier, ev_rem_fault, ev_unlock, ev_jabber;
  logic        link_up, partner_pause, speed_100, full_duplex;
  logic [2:0]  an_state;
  logic        rd_stb, wr_en;
  logic [1:0]  wr_cfg;
  logic [15:0] rd_data;
  logic        irq;
  int          total = 0;
  int          fails = 0;

  always #10 clk = ~clk;

  qsr_status_reg u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_err(ev_rx_err), .ev_false_carrier(ev_false_carrier),
    .ev_rem_fault(ev_rem_fault), .ev_unlock(ev_unlock), .ev_jabber(ev_jabber),
    .link_up(link_up), .partner_pause(partner_pause), .speed_100(speed_100),
    .full_duplex(full_duplex), .an_state(an_state), .rd_stb(rd_stb),
    .wr_en(wr_en), .wr_cfg(wr_cfg), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic read_clear();
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
  endtask

  task automatic write_cfg(input logic [1:0] v);
    wr_en  = 1'b1;
    wr_cfg = v;
    tick();
    wr_en  = 1'b0;
  endtask

  task automatic pulse_clear();
    ev_rx_err = 0; ev_false_carrier = 0; ev_rem_fault = 0; ev_unlock = 0; ev_jabber = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    pulse_clear();
    link_up = 0; partner_pause = 0; speed_100 = 0; full_duplex = 0;
    an_state = 3'd0; rd_stb = 0; wr_en = 0; wr_cfg = 2'b00;
    repeat (3) tick();
    chk("R1 reset word", rd_data, 16'h0000);
    chk("R1 reset irq", irq, 1'b0);

    rst_n   = 1'b1;
    link_up = 1'b1;
    tick();
    chk("R6 link latched low after reset", rd_data[11], 1'b0);
    chk("R9 irq on low link", irq, 1'b1);
    rd_stb = 1'b1; #1;
    chk("R6 read returns low link", rd_data[11], 1'b0);
    tick(); rd_stb = 1'b0;
    chk("R6 link reloaded by read", rd_data[11], 1'b1);
    chk("R9 irq drops after read", irq, 1'b0);

    // Sticky events at both speeds
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 5; e++) begin
        logic [3:0] exp_n;
        string      tg;
        speed_100 = s[0];
        read_clear();
        case (e)
          0: begin ev_rx_err = 1;        exp_n = s ? 4'h8 : 4'h0; tg = "R2 rx error"; end
          1: begin ev_false_carrier = 1; exp_n = s ? 4'h4 : 4'h0; tg = "R3 false carrier"; end
          2: begin ev_rem_fault = 1;     exp_n = 4'h2;            tg = "R3 remote fault"; end
          3: begin ev_unlock = 1;        exp_n = s ? 4'h1 : 4'h0; tg = "R4 unlock"; end
          default: begin ev_jabber = 1;  exp_n = s ? 4'h0 : 4'h1; tg = "R4 jabber"; end
        endcase
        tick();
        pulse_clear();
        chk(tg, rd_data[15:12], exp_n);
        chk("R9 irq follows sticky", irq, exp_n != 4'h0);
        tick();
        chk("R5 sticky holds", rd_data[15:12], exp_n);
        rd_stb = 1'b1; #1;
        chk("R5 read returns pre-clear", rd_data[15:12], exp_n);
        tick(); rd_stb = 1'b0;
        chk("R5 cleared after read", rd_data[15:12], 4'h0);
        chk("R9 irq cleared after read", irq, 1'b0);
      end
    end

    // Event coincident with a read
    speed_100 = 1'b1;
    ev_rem_fault = 1'b1; rd_stb = 1'b1;
    tick();
    pulse_clear(); rd_stb = 1'b0;
    chk("R5 event in read cycle survives", rd_data[13], 1'b1);
    read_clear();
    chk("R5 cleared on second read", rd_data[13], 1'b0);

    // Latch-low link
    link_up = 0; tick(); link_up = 1; tick(); tick();
    chk("R6 stays low after link returns", rd_data[11], 1'b0);
    chk("R9 irq while link latched low", irq, 1'b1);
    read_clear();
    chk("R6 reloaded high", rd_data[11], 1'b1);
    chk("R9 irq clear", irq, 1'b0);
    link_up = 0; tick(); read_clear();
    chk("R6 read with link down reloads low", rd_data[11], 1'b0);
    link_up = 1; tick();
    chk("R6 remains low until next read", rd_data[11], 1'b0);
    read_clear();
    chk("R6 high after next read", rd_data[11], 1'b1);

    // Live levels
    for (int v = 0; v < 8; v++) begin
      {partner_pause, speed_100, full_duplex} = v[2:0];
      tick();
      chk("R7 live levels", rd_data[10:8], v[2:0]);
    end
    speed_100 = 1'b1;
    read_clear();

    // Mode 1
    write_cfg(2'b10);
    chk("R8 config written", rd_data[7:6], 2'b10);
    ev_rx_err = 1; tick(); pulse_clear();
    chk("R10 bit15 still records", rd_data[15], 1'b1);
    chk("R10 bit14 is link change", rd_data[14], 1'b0);
    chk("R10 irq ignores rx error", irq, 1'b0);
    link_up = 0; tick(); link_up = 1; tick();
    chk("R10 link change flag", rd_data[14], 1'b1);
    chk("R10 irq on link change", irq, 1'b1);
    read_clear();
    chk("R10 flag cleared", rd_data[14], 1'b0);
    chk("R10 irq cleared", irq, 1'b0);

    // Mask in mode 1
    write_cfg(2'b11);
    link_up = 0; tick(); link_up = 1; tick();
    chk("R10 flag under mask", rd_data[14], 1'b1);
    chk("R11 masked mode1 irq", irq, 1'b0);
    read_clear();

    // Mask in mode 0
    write_cfg(2'b01);
    chk("R8 config written mask", rd_data[7:6], 2'b01);
    link_up = 0; ev_rem_fault = 1; tick(); pulse_clear();
    chk("R11 masked link low", rd_data[11], 1'b0);
    chk("R11 masked irq", irq, 1'b0);
    write_cfg(2'b00);
    chk("R9 irq after unmask", irq, 1'b1);
    link_up = 1; tick(); read_clear();
    chk("R9 irq cleared after unmask read", irq, 1'b0);

    // Autonegotiation min/max over all ordered pairs
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        an_state = a[2:0];
        read_clear();
        chk("R12 reload low", rd_data[5:3], a[2:0]);
        chk("R12 reload high", rd_data[2:0], a[2:0]);
        an_state = b[2:0];
        tick();
        chk("R12 minimum", rd_data[5:3], (a < b) ? a[2:0] : b[2:0]);
        chk("R12 maximum", rd_data[2:0], (a > b) ? a[2:0] : b[2:0]);
      end
    end

    summary();
  end

endmodule